// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This block takes a linear byte address and the tiling layout of the access (linear, X-tiled or Y-tiled). It returns the same address with bit 6 replaced by the XOR of bit 6 and a set of higher address bits. Which higher bits are used depends on the tiling layout and on the memory-channel arrangement. The result matches the channel interleave that the memory controller applies. Address bits other than bit 6 pass through untouched. The result is registered, and a valid flag follows the request by one cycle.

A small mode register sits inside the block. It is loaded from a memory-configuration descriptor, which arrives as plain input ports with a load strobe. The descriptor holds the channel addressing mode, a channel XOR randomization enable, a select between address bit 11 and address bit 17 as the extra randomization term, and the populated sizes of the two channels. From these fields the block derives one swizzle mode for X-tiled accesses and one for Y-tiled accesses. A descriptor made of all ones is taken as a failed configuration read. In that case the mode is marked unknown and tiled accesses fall back to linear with no swizzle. Each access reports the 3-bit swizzle mode it used and its effective tiling layout.

Top module: `swz_bit6_top`

## Requirements
- R1: With an interleaved channel mode (chan code 2), equal channel sizes and randomization off, X-tiled accesses XOR bits 9 and 10 into bit 6 and report mode code 2.
- R2: Under the same configuration as R1, Y-tiled accesses XOR only bit 9 into bit 6 and report mode code 1.
- R3: With randomization on and the high-bit select clear, bit 11 is added: X uses 9,10,11 (code 4) and Y uses 9,11 (code 3).
- R4: With randomization on and the high-bit select set, bit 17 replaces bit 11: X uses 9,10,17 (code 6) and Y uses 9,17 (code 5).
- R5: Single-channel (chan code 0), asymmetric dual-channel (chan code 1) and the reserved chan code 3 give mode code 0 for both layouts, and bit 6 is left unchanged.
- R6: An interleaved configuration whose two channel sizes differ gives mode code 0 for both layouts.
- R7: A descriptor with every field all ones sets both modes to unknown (code 7). A tiled access is then reported with layout linear (code 0) and mode code 7, and its address is unchanged.
- R8: Linear accesses (layout code 0) and the reserved layout code 3 are never swizzled. They report mode code 0 and layout code 0.
- R9: The output appears one cycle after the request, and valid_out equals valid_in of the previous cycle. All address bits except bit 6 equal the input bits.
- R10: After reset valid_out is 0 and both modes are code 0. Until the first load, a tiled access is therefore unswizzled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads the descriptor fields into the mode register |
| cfg_chan | input | 2 | Channel mode: 0 single, 1 asymmetric, 2 interleaved, 3 reserved |
| cfg_xor_en | input | 1 | Channel XOR randomization enable |
| cfg_xor_hi | input | 1 | Randomization term: 0 bit 11, 1 bit 17 |
| cfg_size_a | input | SIZE_W | Populated size of channel A |
| cfg_size_b | input | SIZE_W | Populated size of channel B |
| valid_in | input | 1 | Access request |
| tile_in | input | 2 | Layout: 0 linear, 1 X, 2 Y, 3 reserved (linear) |
| addr_in | input | ADDR_W | Byte address |
| valid_out | output | 1 | Result valid |
| addr_out | output | ADDR_W | Swizzled address |
| mode_out | output | 3 | Swizzle mode used (0 none,1 9,2 9_10,3 9_11,4 9_10_11,5 9_17,6 9_10_17,7 unknown) |
| tile_out | output | 2 | Effective layout after the unknown fallback |

## Verification
The bench builds the block with ADDR_W=24 and SIZE_W=4. A 4-bit size field makes equal channel sizes frequent under random descriptors, so the swizzling and size-mismatch paths are both reached often. It also makes the all-ones descriptor a value that a directed case can set at once. A 24-bit address still covers bit 17, so the bit-17 randomization term is exercised against random upper address bits.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [1:0] {
        TILE_LIN = 2'd0,
        TILE_X   = 2'd1,
        TILE_Y   = 2'd2,
        TILE_RSV = 2'd3
    } tile_e;

    typedef enum logic [1:0] {
        CH_SINGLE = 2'd0,
        CH_ASYM   = 2'd1,
        CH_ILV    = 2'd2,
        CH_RSV    = 2'd3
    } chan_e;

    typedef enum logic [2:0] {
        SW_NONE     = 3'd0,
        SW_9        = 3'd1,
        SW_9_10     = 3'd2,
        SW_9_11     = 3'd3,
        SW_9_10_11  = 3'd4,
        SW_9_17     = 3'd5,
        SW_9_10_17  = 3'd6,
        SW_UNK      = 3'd7
    } swz_e;

    typedef struct packed {
        swz_e x_mode;
        swz_e y_mode;
    } swz_pair_t;

    localparam int TARGET_BIT = 6;
    localparam int NUM_TAPS   = 4;

    // tap vector order: [0] bit 9, [1] bit 10, [2] bit 11, [3] bit 17
    function automatic logic [NUM_TAPS-1:0] tap_mask(swz_e m);
        case (m)
            SW_9:       return 4'b0001;
            SW_9_10:    return 4'b0011;
            SW_9_11:    return 4'b0101;
            SW_9_10_11: return 4'b0111;
            SW_9_17:    return 4'b1001;
            SW_9_10_17: return 4'b1011;
            default:    return 4'b0000;
        endcase
    endfunction

    function automatic swz_pair_t derive_modes(chan_e ch, logic xor_en, logic xor_hi,
                                               logic sizes_eq, logic all_ones);
        swz_pair_t p;
        if (all_ones) begin
            p.x_mode = SW_UNK;
            p.y_mode = SW_UNK;
        end else if (ch != CH_ILV || !sizes_eq) begin
            p.x_mode = SW_NONE;
            p.y_mode = SW_NONE;
        end else if (!xor_en) begin
            p.x_mode = SW_9_10;
            p.y_mode = SW_9;
        end else if (xor_hi) begin
            p.x_mode = SW_9_10_17;
            p.y_mode = SW_9_17;
        end else begin
            p.x_mode = SW_9_10_11;
            p.y_mode = SW_9_11;
        end
        return p;
    endfunction

endpackage

// File: rtl/swz_cfg_reg.sv
module swz_cfg_reg
    import swz_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  chan_e             chan,
    input  logic              xor_en,
    input  logic              xor_hi,
    input  logic [SIZE_W-1:0] size_a,
    input  logic [SIZE_W-1:0] size_b,
    output swz_pair_t         modes
);
    localparam int DESC_W = 4 + 2 * SIZE_W;

    logic [DESC_W-1:0] desc;
    logic              all_ones;
    swz_pair_t         next_modes;

    assign desc       = {chan, xor_en, xor_hi, size_a, size_b};
    assign all_ones   = &desc;
    assign next_modes = derive_modes(chan, xor_en, xor_hi, size_a == size_b, all_ones);

    always_ff @(posedge clk) begin
        if (rst) begin
            modes.x_mode <= SW_NONE;
            modes.y_mode <= SW_NONE;
        end else if (load) begin
            modes <= next_modes;
        end
    end

    a_r7_unknown_load: assert property (@(posedge clk) disable iff (rst)
        (load && all_ones) |=> (modes.x_mode == SW_UNK && modes.y_mode == SW_UNK));

    a_r6_size_mismatch: assert property (@(posedge clk) disable iff (rst)
        (load && !all_ones && size_a != size_b) |=> (modes.x_mode == SW_NONE && modes.y_mode == SW_NONE));

    a_r5_not_interleaved: assert property (@(posedge clk) disable iff (rst)
        (load && !all_ones && chan != CH_ILV) |=> (modes.x_mode == SW_NONE && modes.y_mode == SW_NONE));

    a_r10_reset_modes: assert property (@(posedge clk)
        rst |=> (modes.x_mode == SW_NONE && modes.y_mode == SW_NONE));

endmodule

// File: rtl/swz_bit_mix.sv
module swz_bit_mix
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  tile_e             tile,
    input  swz_pair_t         modes,
    output logic [ADDR_W-1:0] addr_sw,
    output swz_e              mode_eff,
    output tile_e             tile_eff
);
    localparam int HI_BIT = 17;

    swz_e                 sel;
    logic [NUM_TAPS-1:0]  taps;
    logic [NUM_TAPS-1:0]  bits;
    logic                 flip;

    always_comb begin
        case (tile)
            TILE_X:  sel = modes.x_mode;
            TILE_Y:  sel = modes.y_mode;
            default: sel = SW_NONE;
        endcase
    end

    assign bits     = {addr[HI_BIT], addr[11], addr[10], addr[9]};
    assign taps     = tap_mask(sel);
    assign flip     = ^(taps & bits);
    assign mode_eff = sel;
    assign tile_eff = (sel == SW_UNK || tile == TILE_RSV) ? TILE_LIN : tile;

    always_comb begin
        addr_sw             = addr;
        addr_sw[TARGET_BIT] = addr[TARGET_BIT] ^ flip;
    end

endmodule

// File: rtl/swz_bit6_top.sv
module swz_bit6_top
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_chan,
    input  logic              cfg_xor_en,
    input  logic              cfg_xor_hi,
    input  logic [SIZE_W-1:0] cfg_size_a,
    input  logic [SIZE_W-1:0] cfg_size_b,
    input  logic              valid_in,
    input  logic [1:0]        tile_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              valid_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic [2:0]        mode_out,
    output logic [1:0]        tile_out
);
    localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << TARGET_BIT);

    swz_pair_t         modes;
    logic [ADDR_W-1:0] mix_addr;
    swz_e              mix_mode;
    tile_e             mix_tile;

    swz_cfg_reg #(.SIZE_W(SIZE_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .chan   (chan_e'(cfg_chan)),
        .xor_en (cfg_xor_en),
        .xor_hi (cfg_xor_hi),
        .size_a (cfg_size_a),
        .size_b (cfg_size_b),
        .modes  (modes)
    );

    swz_bit_mix #(.ADDR_W(ADDR_W)) u_mix (
        .addr     (addr_in),
        .tile     (tile_e'(tile_in)),
        .modes    (modes),
        .addr_sw  (mix_addr),
        .mode_eff (mix_mode),
        .tile_eff (mix_tile)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            addr_out  <= '0;
            mode_out  <= SW_NONE;
            tile_out  <= TILE_LIN;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                addr_out <= mix_addr;
                mode_out <= mix_mode;
                tile_out <= mix_tile;
            end
        end
    end

    a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    a_r9_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    a_r9_other_bits: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> ((addr_out & KEEP_MASK) == ($past(addr_in) & KEEP_MASK)));

    a_r8_linear_clean: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (tile_in == 2'd0 || tile_in == 2'd3)) |=>
            (addr_out == $past(addr_in) && mode_out == 3'd0 && tile_out == 2'd0));

    a_r7_unknown_linear: assert property (@(posedge clk) disable iff (rst)
        (valid_out && mode_out == 3'd7) |-> tile_out == 2'd0);

    a_r10_reset_valid: assert property (@(posedge clk)
        rst |=> !valid_out);

endmodule

// File: tb/swz_bit6_top_tb_top.sv
module swz_bit6_top_tb_top;
    localparam int AW = 24;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_load;
    logic [1:0]    cfg_chan;
    logic          cfg_xor_en;
    logic          cfg_xor_hi;
    logic [SW-1:0] cfg_size_a;
    logic [SW-1:0] cfg_size_b;
    logic          valid_in;
    logic [1:0]    tile_in;
    logic [AW-1:0] addr_in;
    logic          valid_out;
    logic [AW-1:0] addr_out;
    logic [2:0]    mode_out;
    logic [1:0]    tile_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // configuration currently held by the block, as the bench believes
    logic [1:0]    cur_chan;
    logic          cur_xe, cur_xs;
    logic [SW-1:0] cur_sa, cur_sb;

    always #2 clk = ~clk;

    swz_bit6_top #(.ADDR_W(AW), .SIZE_W(SW)) dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_chan(cfg_chan),
        .cfg_xor_en(cfg_xor_en), .cfg_xor_hi(cfg_xor_hi),
        .cfg_size_a(cfg_size_a), .cfg_size_b(cfg_size_b),
        .valid_in(valid_in), .tile_in(tile_in), .addr_in(addr_in),
        .valid_out(valid_out), .addr_out(addr_out),
        .mode_out(mode_out), .tile_out(tile_out)
    );

    function automatic logic [2:0] exp_mode(logic [1:0] tile);
        logic all1;
        all1 = (cur_chan == 2'b11) && cur_xe && cur_xs && (&cur_sa) && (&cur_sb);
        if (tile != 2'd1 && tile != 2'd2) return 3'd0;
        if (all1) return 3'd7;
        if (cur_chan != 2'd2 || cur_sa != cur_sb) return 3'd0;
        if (!cur_xe) return (tile == 2'd1) ? 3'd2 : 3'd1;
        if (cur_xs) return (tile == 2'd1) ? 3'd6 : 3'd5;
        return (tile == 2'd1) ? 3'd4 : 3'd3;
    endfunction

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic [2:0] m);
        logic f;
        case (m)
            3'd1: f = a[9];
            3'd2: f = a[9] ^ a[10];
            3'd3: f = a[9] ^ a[11];
            3'd4: f = a[9] ^ a[10] ^ a[11];
            3'd5: f = a[9] ^ a[17];
            3'd6: f = a[9] ^ a[10] ^ a[17];
            default: f = 1'b0;
        endcase
        exp_addr = a;
        exp_addr[6] = a[6] ^ f;
    endfunction

    function automatic string req_of(logic [2:0] m, logic [1:0] t);
        if (t == 2'd0 || t == 2'd3) return "R8";
        case (m)
            3'd1: return "R2";
            3'd2: return "R1";
            3'd3, 3'd4: return "R3";
            3'd5, 3'd6: return "R4";
            3'd7: return "R7";
            default: return (cur_chan == 2'd2) ? "R6" : "R5";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_cfg(logic [1:0] ch, logic xe, logic xs, logic [SW-1:0] sa, logic [SW-1:0] sb);
        @(negedge clk);
        cfg_load = 1'b1; cfg_chan = ch; cfg_xor_en = xe; cfg_xor_hi = xs;
        cfg_size_a = sa; cfg_size_b = sb;
        @(negedge clk);
        cfg_load = 1'b0;
        cur_chan = ch; cur_xe = xe; cur_xs = xs; cur_sa = sa; cur_sb = sb;
    endtask

    task automatic access(logic [1:0] t, logic [AW-1:0] a);
        logic [2:0] em;
        logic [1:0] et;
        string r;
        em = exp_mode(t);
        et = (t == 2'd3 || em == 3'd7) ? 2'd0 : t;
        r  = req_of(em, t);
        @(negedge clk);
        valid_in = 1'b1; tile_in = t; addr_in = a;
        @(negedge clk);
        valid_in = 1'b0;
        check("R9 valid", 32'(valid_out), 32'd1);
        check({r, " addr"}, 32'(addr_out), 32'(exp_addr(a, em)));
        check({r, " mode"}, 32'(mode_out), 32'(em));
        check({r, " tile"}, 32'(tile_out), 32'(et));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'd20250611));
        rst = 1'b1; cfg_load = 0; cfg_chan = 0; cfg_xor_en = 0; cfg_xor_hi = 0;
        cfg_size_a = 0; cfg_size_b = 0; valid_in = 0; tile_in = 0; addr_in = 0;
        cur_chan = 0; cur_xe = 0; cur_xs = 0; cur_sa = 0; cur_sb = 0;
        repeat (3) @(negedge clk);
        check("R10 valid_out reset", 32'(valid_out), 32'd0);
        rst = 1'b0;
        // R10: before any load a tiled access is not swizzled
        access(2'd1, 24'h000240);
        access(2'd2, 24'h000200);
        // R1/R2 base interleave
        load_cfg(2'd2, 1'b0, 1'b0, 4'd5, 4'd5);
        access(2'd1, 24'h000200);
        access(2'd1, 24'h000600);
        access(2'd2, 24'h000400);
        access(2'd2, 24'h000240);
        // R3 bit 11 randomization
        load_cfg(2'd2, 1'b1, 1'b0, 4'd3, 4'd3);
        access(2'd1, 24'h000800);
        access(2'd2, 24'h000A40);
        access(2'd1, 24'h020000);
        // R4 bit 17 randomization
        load_cfg(2'd2, 1'b1, 1'b1, 4'd3, 4'd3);
        access(2'd1, 24'h020000);
        access(2'd2, 24'h020800);
        // R5 non-interleaved modes
        load_cfg(2'd0, 1'b0, 1'b0, 4'd2, 4'd2);
        access(2'd1, 24'h000200);
        load_cfg(2'd1, 1'b1, 1'b0, 4'd2, 4'd2);
        access(2'd2, 24'h000200);
        load_cfg(2'd3, 1'b1, 1'b1, 4'd2, 4'd2);
        access(2'd1, 24'h000E00);
        // R6 size mismatch
        load_cfg(2'd2, 1'b1, 1'b0, 4'd2, 4'd3);
        access(2'd1, 24'h000E00);
        // R7 all-ones descriptor
        load_cfg(2'd3, 1'b1, 1'b1, 4'hF, 4'hF);
        access(2'd1, 24'h020E40);
        access(2'd2, 24'h000200);
        // R8 linear and reserved layout under swizzling config
        load_cfg(2'd2, 1'b0, 1'b0, 4'd1, 4'd1);
        access(2'd0, 24'h000600);
        access(2'd3, 24'h000200);
        // R9 valid drops after an idle cycle
        @(negedge clk);
        check("R9 valid idle", 32'(valid_out), 32'd0);
        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 8 == 0) begin
                logic [SW-1:0] sa;
                sa = SW'($urandom);
                load_cfg(2'($urandom), 1'($urandom), 1'($urandom), sa,
                         ($urandom % 2) ? sa : SW'($urandom));
            end
            a = AW'($urandom);
            access(2'($urandom), a);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule